// File: doc/BRIEF.md
# Redial Memory Dial Controller

This block is the control core of a telephone dialer that can signal in tone or pulse form. It takes decoded key events and a hook input. It also reads back the busy flags of two external signal generators, one for tone and one for pulse. For each digit it raises a request to the generator that matches the current signalling form. It records what the user keys into a 32-entry memory so that the number can be dialed again with one key.

Timed pauses and a pulse-to-tone switch are stored in the memory as entries of their own. Replaying a number therefore repeats the pauses and the switch in the same places. A three-level lock input can bar numbers that start with 0, or with 0 or 9. When lock is active, the first key is also held back after off-hook, and so is the first digit sent.

All durations are given in clock cycles through parameters. The key codes and the entry codes share one 4-bit encoding.

Top module: `dial_ctl`

## Requirements
- R1: The memory holds at most DEPTH (32) entries. Manual entries beyond the 32nd are still dialed but are not stored.
- R2: Key codes on `key_i` are: 0..9 for digits, 10 for star/T, 11 for hash, 12 for the long pause/redial key, and 13 for the short pause/redial key. Codes 14 and 15 are ignored. Stored entries use the same codes, and code 14 marks a pulse-to-tone switch.
- R3: If the first accepted key after off-hook is 12 or 13, the stored entries are replayed in order from address 0. If the memory is empty, this key produces no output.
- R4: Any other first accepted key after off-hook clears the memory and stores itself at address 0. Later keys of the same call are appended.
- R5: Entry 12 idles for LONG_CYC cycles and entry 13 idles for SHORT_CYC cycles before the next entry, both when keyed and when replayed.
- R6: In tone signalling, star sends tone code 10. In pulse signalling, star sends nothing, switches the rest of the call to tone, and is stored as 14, so a replay switches at the same point.
- R7: A digit is sent by raising `tone_req_o` or `pulse_req_o` with `digit_o` held stable until the matching busy flag is seen high. The next entry waits until both busy flags are low. A pulse request only ever carries 0..9. Hash in pulse signalling sends nothing.
- R8: `lock_sel_i`: 0 or 3 means no lock, 1 bars 0 and 9, and 2 bars 0 only. If the first accepted key is barred, that key and every later key give no output until on-hook or reset.
- R9: With lock 1 or 2, keys are ignored for LOCK_CYC cycles after off-hook, and the first keyed digit is sent no earlier than LOCK_CYC cycles after its key.
- R10: While `hook_i` is high, or while in reset, no request is raised and keys are ignored. Going on-hook aborts any dialing.
- R11: Keys that arrive while an entry is being sent, paused or replayed are ignored. They are neither dialed nor stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hook_i | input | 1 | 1 = on-hook (sleep), 0 = off-hook |
| tone_sel_i | input | 1 | Signalling form at off-hook: 1 tone, 0 pulse |
| lock_sel_i | input | 2 | Lock level, see R8 |
| key_vld_i | input | 1 | One-cycle key event strobe |
| key_i | input | 4 | Key code, see R2 |
| tone_busy_i | input | 1 | Tone generator busy |
| pulse_busy_i | input | 1 | Pulse generator busy |
| tone_req_o | output | 1 | Tone digit request |
| pulse_req_o | output | 1 | Pulse digit request |
| digit_o | output | 4 | Code carried by the active request |

## Verification
The assertions check several behaviours on every cycle. The two requests are never high together. A pulse request never carries a code above 9. A request and its code hold until the generator answers. Requests stay low on-hook and in the barred state. The memory count never passes its depth, and it does not move while a replay is running. The pause timer also steps down by one each cycle.

Only the bench scenarios can show the rest. That covers the order and form of replayed entries, the pause and lock delay lengths measured between events, the point where a call switches from pulse to tone, and the loss of keys pressed during a replay.

// File: rtl/dialctl_pkg.sv
package dialctl_pkg;

    typedef enum logic [3:0] {
        S_SLEEP,
        S_HOLD,
        S_IDLE,
        S_DLY1,
        S_EXEC,
        S_REQ,
        S_WAIT,
        S_PAUSE,
        S_LOCK
    } dst_e;

    localparam logic [3:0] C_STAR   = 4'd10;
    localparam logic [3:0] C_HASH   = 4'd11;
    localparam logic [3:0] C_PLONG  = 4'd12;
    localparam logic [3:0] C_PSHORT = 4'd13;
    localparam logic [3:0] C_P2T    = 4'd14;
    localparam logic [3:0] C_LAST_D = 4'd9;

endpackage

// File: rtl/dial_store.sv
module dial_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  logic          append_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o,
    output logic [AW:0]   count_o
);

    localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW:0]              cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart_i) begin
            st_d.mem[0] = wdata_i;
            st_d.cnt    = (AW+1)'(1);
        end else if (append_i && (st_q.cnt < DEPTH_L)) begin
            st_d.mem[st_q.cnt[AW-1:0]] = wdata_i;
            st_d.cnt                   = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o = st_q.mem[raddr_i];
    assign count_o = st_q.cnt;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= DEPTH_L); // R1
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == DEPTH_L) && append_i && !restart_i |=> st_q.cnt == DEPTH_L); // R1
    AST_RESTART_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> st_q.cnt == (AW+1)'(1)); // R4

endmodule

// File: rtl/dial_tmr.sv
module dial_tmr #(
    parameter int TW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] len_i,
    output logic          done_o
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)            cnt_d = len_i;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == TW'(1));

    AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) && !load_i |=> cnt_q == $past(cnt_q) - 1'b1); // R5

endmodule

// File: rtl/dial_lockchk.sv
module dial_lockchk (
    input  logic [1:0] lock_sel_i,
    input  logic [3:0] key_i,
    output logic       lock_on_o,
    output logic       inhibit_o
);

    logic bar_zero, bar_nine;

    always_comb begin
        bar_zero  = (lock_sel_i == 2'd1) || (lock_sel_i == 2'd2);
        bar_nine  = (lock_sel_i == 2'd1);
        lock_on_o = bar_zero;
        inhibit_o = (bar_zero && key_i == 4'd0) || (bar_nine && key_i == 4'd9);
    end

endmodule

// File: rtl/dial_ctl.sv
module dial_ctl
    import dialctl_pkg::*;
#(
    parameter int DEPTH     = 32,
    parameter int LONG_CYC  = 360,
    parameter int SHORT_CYC = 200,
    parameter int LOCK_CYC  = 30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hook_i,
    input  logic       tone_sel_i,
    input  logic [1:0] lock_sel_i,
    input  logic       key_vld_i,
    input  logic [3:0] key_i,
    input  logic       tone_busy_i,
    input  logic       pulse_busy_i,
    output logic       tone_req_o,
    output logic       pulse_req_o,
    output logic [3:0] digit_o
);

    localparam int AW   = $clog2(DEPTH);
    localparam int MAXP = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int MAXT = (MAXP > LOCK_CYC) ? MAXP : LOCK_CYC;
    localparam int TW   = $clog2(MAXT + 1);
    localparam logic [TW-1:0] LONG_L  = TW'(LONG_CYC);
    localparam logic [TW-1:0] SHORT_L = TW'(SHORT_CYC);
    localparam logic [TW-1:0] LOCK_L  = TW'(LOCK_CYC);

    typedef struct packed {
        dst_e        st;
        logic [3:0]  cur;
        logic [AW:0] rd;
        logic        play;
        logic        first;
        logic        tone_act;
        logic        treq;
        logic        preq;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          mem_restart, mem_append;
    logic [3:0]    mem_wdata, mem_rdata;
    logic [AW:0]   mem_cnt;
    logic          tmr_load, tmr_done;
    logic [TW-1:0] tmr_len;
    logic          lock_on, key_barred;

    dial_store #(.DEPTH(DEPTH), .DW(4)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (mem_restart),
        .append_i  (mem_append),
        .wdata_i   (mem_wdata),
        .raddr_i   (ctl_q.rd[AW-1:0]),
        .rdata_o   (mem_rdata),
        .count_o   (mem_cnt)
    );

    dial_tmr #(.TW(TW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .len_i  (tmr_len),
        .done_o (tmr_done)
    );

    dial_lockchk u_lock (
        .lock_sel_i (lock_sel_i),
        .key_i      (key_i),
        .lock_on_o  (lock_on),
        .inhibit_o  (key_barred)
    );

    always_comb begin
        logic [3:0]  ent;
        logic        fin;
        logic [AW:0] rd_nx;
        ctl_d       = ctl_q;
        mem_restart = 1'b0;
        mem_append  = 1'b0;
        mem_wdata   = key_i;
        tmr_load    = 1'b0;
        tmr_len     = LOCK_L;
        fin         = 1'b0;
        ent         = ctl_q.play ? mem_rdata : ctl_q.cur;
        rd_nx       = ctl_q.rd + 1'b1;

        if (hook_i) begin
            ctl_d.st   = S_SLEEP;
            ctl_d.treq = 1'b0;
            ctl_d.preq = 1'b0;
            ctl_d.play = 1'b0;
        end else begin
            case (ctl_q.st)
                S_SLEEP: begin
                    ctl_d.first    = 1'b1;
                    ctl_d.play     = 1'b0;
                    ctl_d.rd       = '0;
                    ctl_d.tone_act = tone_sel_i;
                    if (lock_on) begin
                        tmr_load = 1'b1;
                        tmr_len  = LOCK_L;
                        ctl_d.st = S_HOLD;
                    end else begin
                        ctl_d.st = S_IDLE;
                    end
                end
                S_HOLD: if (tmr_done) ctl_d.st = S_IDLE;
                S_IDLE: begin
                    if (key_vld_i && (key_i < C_P2T)) begin
                        ctl_d.first = 1'b0;
                        if (ctl_q.first && (key_i == C_PLONG || key_i == C_PSHORT)) begin
                            if (mem_cnt != '0) begin
                                ctl_d.play = 1'b1;
                                ctl_d.rd   = '0;
                                ctl_d.st   = S_EXEC;
                            end
                        end else if (ctl_q.first && key_barred) begin
                            ctl_d.st = S_LOCK;
                        end else begin
                            mem_wdata = (key_i == C_STAR && !ctl_q.tone_act) ? C_P2T : key_i;
                            ctl_d.cur = mem_wdata;
                            if (ctl_q.first) mem_restart = 1'b1;
                            else             mem_append  = 1'b1;
                            if (ctl_q.first && lock_on) begin
                                tmr_load = 1'b1;
                                tmr_len  = LOCK_L;
                                ctl_d.st = S_DLY1;
                            end else begin
                                ctl_d.st = S_EXEC;
                            end
                        end
                    end
                end
                S_DLY1: if (tmr_done) ctl_d.st = S_EXEC;
                S_EXEC: begin
                    ctl_d.cur = ent;
                    if (ent <= C_LAST_D) begin
                        if (ctl_q.tone_act) ctl_d.treq = 1'b1;
                        else                ctl_d.preq = 1'b1;
                        ctl_d.st = S_REQ;
                    end else if (ent == C_STAR || ent == C_HASH) begin
                        if (ctl_q.tone_act) begin
                            ctl_d.treq = 1'b1;
                            ctl_d.st   = S_REQ;
                        end else begin
                            if (ent == C_STAR) ctl_d.tone_act = 1'b1;
                            fin = 1'b1;
                        end
                    end else if (ent == C_PLONG || ent == C_PSHORT) begin
                        tmr_load = 1'b1;
                        tmr_len  = (ent == C_PLONG) ? LONG_L : SHORT_L;
                        ctl_d.st = S_PAUSE;
                    end else begin
                        if (ent == C_P2T) ctl_d.tone_act = 1'b1;
                        fin = 1'b1;
                    end
                end
                S_REQ: begin
                    if ((ctl_q.treq && tone_busy_i) || (ctl_q.preq && pulse_busy_i)) begin
                        ctl_d.treq = 1'b0;
                        ctl_d.preq = 1'b0;
                        ctl_d.st   = S_WAIT;
                    end
                end
                S_WAIT:  if (!tone_busy_i && !pulse_busy_i) fin = 1'b1;
                S_PAUSE: if (tmr_done) fin = 1'b1;
                S_LOCK:  ctl_d.st = S_LOCK;
                default: ctl_d.st = S_SLEEP;
            endcase

            if (fin) begin
                if (ctl_q.play && (rd_nx < mem_cnt)) begin
                    ctl_d.rd = rd_nx;
                    ctl_d.st = S_EXEC;
                end else begin
                    ctl_d.play = 1'b0;
                    ctl_d.st   = S_IDLE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st       <= S_SLEEP;
            ctl_q.cur      <= '0;
            ctl_q.rd       <= '0;
            ctl_q.play     <= 1'b0;
            ctl_q.first    <= 1'b0;
            ctl_q.tone_act <= 1'b0;
            ctl_q.treq     <= 1'b0;
            ctl_q.preq     <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign tone_req_o  = ctl_q.treq;
    assign pulse_req_o = ctl_q.preq;
    assign digit_o     = ctl_q.cur;

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(tone_req_o && pulse_req_o)); // R7
    AST_PULSE_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_req_o |-> digit_o <= C_LAST_D); // R7
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tone_req_o && !tone_busy_i && !hook_i |=> tone_req_o && $stable(digit_o)); // R7
    AST_SLEEP_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        hook_i |=> !tone_req_o && !pulse_req_o); // R10
    AST_LOCK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == S_LOCK) && !hook_i |=> !tone_req_o && !pulse_req_o); // R8
    AST_PLAY_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.play && key_vld_i && !hook_i |=> $stable(mem_cnt)); // R11

endmodule

// File: tb/dial_ctl_tb_top.sv
module dial_ctl_tb_top;

    localparam int LONG  = 40;
    localparam int SHORT = 20;
    localparam int LOCKC = 16;
    localparam int GEN   = 6;
    localparam int DEP   = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hook = 1'b1;
    logic       tone_sel = 1'b1;
    logic [1:0] lock_sel = 2'd0;
    logic       key_vld = 1'b0;
    logic [3:0] key = 4'd0;
    logic       tone_busy, pulse_busy;
    logic       tone_req, pulse_req;
    logic [3:0] digit;

    int tcnt, pcnt;
    int total = 0;
    int bad = 0;
    int cyc = 0;
    int log_n = 0;
    int log_kind [64];
    int log_code [64];
    int log_gap  [64];
    int log_t    [64];
    int exp_kind [64];
    int exp_code [64];
    int keys     [64];
    int last_fall = 0;
    logic prev_t = 1'b0, prev_p = 1'b0, prev_tb = 1'b0, prev_pb = 1'b0;

    always #10 clk = ~clk;

    dial_ctl #(.DEPTH(DEP), .LONG_CYC(LONG), .SHORT_CYC(SHORT), .LOCK_CYC(LOCKC)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .hook_i       (hook),
        .tone_sel_i   (tone_sel),
        .lock_sel_i   (lock_sel),
        .key_vld_i    (key_vld),
        .key_i        (key),
        .tone_busy_i  (tone_busy),
        .pulse_busy_i (pulse_busy),
        .tone_req_o   (tone_req),
        .pulse_req_o  (pulse_req),
        .digit_o      (digit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt <= 0;
            pcnt <= 0;
        end else begin
            if (tcnt != 0)    tcnt <= tcnt - 1;
            else if (tone_req) tcnt <= GEN;
            if (pcnt != 0)     pcnt <= pcnt - 1;
            else if (pulse_req) pcnt <= GEN;
        end
    end
    assign tone_busy  = (tcnt != 0);
    assign pulse_busy = (pcnt != 0);

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if ((prev_tb && !tone_busy) || (prev_pb && !pulse_busy)) last_fall = cyc;
        if ((tone_req && !prev_t) || (pulse_req && !prev_p)) begin
            if (log_n < 64) begin
                log_kind[log_n] = tone_req ? 1 : 2;
                log_code[log_n] = int'(digit);
                log_gap[log_n]  = cyc - last_fall;
                log_t[log_n]    = cyc;
            end
            log_n = log_n + 1;
        end
        prev_t  = tone_req;
        prev_p  = pulse_req;
        prev_tb = tone_busy;
        prev_pb = pulse_busy;
    end

    function automatic int exp_stored(int n);
        return (n > DEP) ? DEP : n;
    endfunction

    task automatic check_int(string r, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    task automatic check_rng(string r, int act, int lo, int hi);
        total++;
        if (act < lo || act > hi) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", r, act, lo, hi);
        end
    endtask

    task automatic cmp_log(string r, int n);
        check_int({r, " count"}, log_n, n);
        for (int i = 0; i < n && i < log_n && i < 64; i++) begin
            check_int({r, " kind"}, log_kind[i], exp_kind[i]);
            check_int({r, " code"}, log_code[i], exp_code[i]);
        end
    endtask

    task automatic press(int k);
        @(negedge clk);
        key = 4'(k);
        key_vld = 1'b1;
        @(negedge clk);
        key_vld = 1'b0;
    endtask

    task automatic wait_quiet();
        int q = 0;
        while (q < 70) begin
            @(negedge clk);
            if (tone_req || pulse_req || tone_busy || pulse_busy) q = 0;
            else q++;
        end
    endtask

    task automatic off_hook(logic tone);
        @(negedge clk);
        hook = 1'b1;
        repeat (3) @(negedge clk);
        tone_sel = tone;
        hook = 1'b0;
        repeat (LOCKC + 8) @(negedge clk);
        log_n = 0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        check_int("R10 reset tone_req", int'(tone_req), 0);
        check_int("R10 reset pulse_req", int'(pulse_req), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R3: redial with empty memory
        off_hook(1'b1);
        press(12);
        wait_quiet();
        check_int("R3 empty redial", log_n, 0);

        // R1 R2 R4: random manual tone dialing then redial
        for (int round = 0; round < 4; round++) begin
            int n = (round == 0) ? 40 : 1 + int'($urandom % 40);
            off_hook(1'b1);
            for (int i = 0; i < n; i++) begin
                keys[i] = int'($urandom % 12);
                exp_kind[i] = 1;
                exp_code[i] = keys[i];
                press(keys[i]);
                wait_quiet();
            end
            cmp_log("R2 manual", n);
            off_hook(1'b1);
            press(13);
            wait_quiet();
            cmp_log("R1 R3 redial", exp_stored(n));
        end

        // R5: pauses replayed with their lengths
        off_hook(1'b1);
        press(5); wait_quiet();
        press(12); wait_quiet();
        press(7); wait_quiet();
        press(13); wait_quiet();
        press(8); wait_quiet();
        off_hook(1'b1);
        press(13);
        wait_quiet();
        exp_kind[0] = 1; exp_code[0] = 5;
        exp_kind[1] = 1; exp_code[1] = 7;
        exp_kind[2] = 1; exp_code[2] = 8;
        cmp_log("R5 pause replay", 3);
        check_rng("R5 long pause gap", log_gap[1], LONG, LONG + 6);
        check_rng("R5 short pause gap", log_gap[2], SHORT, SHORT + 6);

        // R6: star in pulse switches to tone, kept in replay
        off_hook(1'b0);
        press(3); wait_quiet();
        press(10); wait_quiet();
        press(4); wait_quiet();
        exp_kind[0] = 2; exp_code[0] = 3;
        exp_kind[1] = 1; exp_code[1] = 4;
        cmp_log("R6 pulse to tone", 2);
        off_hook(1'b0);
        press(12);
        wait_quiet();
        cmp_log("R6 pulse to tone replay", 2);

        // R6: star in tone mode; R7: hash in pulse sends nothing
        off_hook(1'b1);
        press(10); wait_quiet();
        exp_kind[0] = 1; exp_code[0] = 10;
        cmp_log("R6 tone star", 1);
        off_hook(1'b0);
        press(11); wait_quiet();
        press(2); wait_quiet();
        exp_kind[0] = 2; exp_code[0] = 2;
        cmp_log("R7 pulse hash dropped", 1);

        // R2: codes 14 and 15 ignored
        off_hook(1'b1);
        press(14); wait_quiet();
        press(15); wait_quiet();
        check_int("R2 unused codes", log_n, 0);

        // R8: lock levels
        lock_sel = 2'd1;
        off_hook(1'b1);
        press(9); wait_quiet();
        press(1); wait_quiet();
        check_int("R8 lock1 nine barred", log_n, 0);
        off_hook(1'b1);
        press(0); wait_quiet();
        press(4); wait_quiet();
        check_int("R8 lock1 zero barred", log_n, 0);
        lock_sel = 2'd2;
        off_hook(1'b1);
        press(9); wait_quiet();
        exp_kind[0] = 1; exp_code[0] = 9;
        cmp_log("R8 lock2 nine allowed", 1);
        off_hook(1'b1);
        press(0); wait_quiet();
        press(5); wait_quiet();
        check_int("R8 lock2 zero barred", log_n, 0);

        // R9: off-hook holdoff and first digit delay
        lock_sel = 2'd1;
        @(negedge clk); hook = 1'b1;
        repeat (3) @(negedge clk);
        hook = 1'b0;
        log_n = 0;
        repeat (3) @(negedge clk);
        press(1);
        repeat (LOCKC + 6) @(negedge clk);
        begin
            int t0;
            t0 = cyc;
            press(5);
            wait_quiet();
            exp_kind[0] = 1; exp_code[0] = 5;
            cmp_log("R9 holdoff key ignored", 1);
            check_rng("R9 first digit delay", log_t[0] - t0, LOCKC, LOCKC + 4);
        end
        lock_sel = 2'd0;

        // R11: keys during replay ignored and not stored
        off_hook(1'b1);
        for (int i = 0; i < 5; i++) begin
            exp_kind[i] = 1; exp_code[i] = i + 1;
            press(i + 1); wait_quiet();
        end
        off_hook(1'b1);
        press(12);
        repeat (10) @(negedge clk);
        press(7);
        wait_quiet();
        cmp_log("R11 key during replay", 5);
        off_hook(1'b1);
        press(12);
        wait_quiet();
        cmp_log("R11 memory unchanged", 5);

        // R10: on-hook aborts replay and ignores keys
        off_hook(1'b1);
        press(12);
        while (log_n == 0) @(negedge clk);
        hook = 1'b1;
        repeat (2) @(negedge clk);
        begin
            int n0;
            n0 = log_n;
            press(3);
            repeat (60) @(negedge clk);
            check_int("R10 on-hook abort", log_n, n0);
            check_int("R10 on-hook quiet", int'(tone_req | pulse_req), 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule